// File: doc/BRIEF.md
# Single-Accumulator 16-bit Processor Core

This block is a compact processor. A single 16-bit accumulator is the only data register. Instructions and data share one word-addressed memory. The memory is reached through one address bus, a read bus and a write bus, with a request strobe and a read/not-write line.

Every instruction takes two clock cycles. In the first cycle the core reads the word at the program counter into the instruction register and advances the counter. In the second cycle it carries out the instruction: a data read, a data write, a change of program counter, or nothing. The core halts on the stop instruction and stays halted until reset.

An instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit direct operand address in bits 11:0. The memory outside the core must return read data within the cycle in which the core requests it.

Top module: `acc_core`

## Requirements
- R1: While reset is high, at a rising edge the core clears the program counter, the accumulator, the instruction register and the halted flag. The first cycle after reset is a read request at address 0.
- R2: The core fetches in one cycle: it reads mem[PC] with mem_req=1 and mem_rd=1, loads the word into the instruction register and increments the PC. The execute cycle follows, so each instruction takes exactly two cycles. The operation code is in bits 15:12 and the operand address S is in bits 11:0.
- R3: Code 0000 loads mem[S] into the accumulator through a read request at address S.
- R4: Code 0001 issues one write request at address S (mem_req=1, mem_rd=0) with the accumulator on mem_wdata. In every other cycle mem_wdata is zero.
- R5: Code 0010 adds mem[S] to the accumulator and code 0011 subtracts mem[S] from it. Both wrap modulo 2^16.
- R6: Code 0100 always loads S into the PC.
- R7: Code 0101 loads S into the PC only when accumulator bit 15 is 0, which means zero or positive.
- R8: Code 0110 loads S into the PC only when the accumulator is not zero.
- R9: Code 0111 sets the halted flag at the end of its execute cycle. After that, no memory request occurs and the flag stays set until reset.
- R10: Codes 1000 through 1111 are no-operations. They leave the accumulator unchanged and execution continues at the next word.
- R11: The jump, stop and no-operation codes make no memory request in their execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request in this cycle |
| mem_rd | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 16 | Write data, the accumulator during a store, otherwise zero |
| mem_rdata | input | 16 | Read data, sampled at the edge ending a read request |
| halted | output | 1 | Core has stopped |

## Verification
The accumulator cannot be seen at the ports. A wrong accumulator value therefore shows up only at the next store, as a wrong mem_wdata, or at the next conditional jump, as a wrong fetch address. Either one appears within a few instructions of the error. A wrong program counter or phase shows up within one or two cycles: an unexpected fetch address, an extra or missing request, or a changed total cycle count to halt. For this reason, each program ends with stores of its results, and the bench checks the memory image, the number of memory requests and the cycles to halt.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam logic [3:0] OPC_LDA = 4'h0;
    localparam logic [3:0] OPC_STO = 4'h1;
    localparam logic [3:0] OPC_ADD = 4'h2;
    localparam logic [3:0] OPC_SUB = 4'h3;
    localparam logic [3:0] OPC_JMP = 4'h4;
    localparam logic [3:0] OPC_JGE = 4'h5;
    localparam logic [3:0] OPC_JNE = 4'h6;
    localparam logic [3:0] OPC_STP = 4'h7;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_HALT  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_fn_e;

    typedef enum logic {
        ASEL_ACC  = 1'b0,
        ASEL_ZERO = 1'b1
    } asel_e;

    typedef enum logic {
        ADDR_PC = 1'b0,
        ADDR_IR = 1'b1
    } addr_sel_e;

    typedef enum logic {
        PCSRC_INC = 1'b0,
        PCSRC_IR  = 1'b1
    } pc_src_e;

    typedef struct packed {
        logic      pc_en;
        pc_src_e   pc_src;
        logic      acc_en;
        logic      ir_en;
        alu_fn_e   alu_fn;
        asel_e     a_sel;
        addr_sel_e addr_sel;
        logic      drive_wdata;
    } dp_ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_fn_e       fn_i,
    output logic [DW-1:0] y_o
);

    always_comb begin
        unique case (fn_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            default: y_o = a_i | b_i;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [3:0] opcode_i,
    input  logic     acc_neg_i,
    input  logic     acc_zero_i,
    output dp_ctrl_t dp_o,
    output logic     mem_req_o,
    output logic     mem_rd_o,
    output phase_e   phase_o
);

    typedef struct packed {
        dp_ctrl_t dp;
        logic     req;
        logic     rd;
        phase_e   phase;
    } ctrl_next_t;

    ctrl_next_t nx_d;
    phase_e     phase_q;

    always_comb begin
        nx_d             = '0;
        nx_d.dp.pc_src   = PCSRC_INC;
        nx_d.dp.alu_fn   = ALU_PASS;
        nx_d.dp.a_sel    = ASEL_ACC;
        nx_d.dp.addr_sel = ADDR_PC;
        nx_d.rd          = 1'b1;
        nx_d.phase       = phase_q;
        unique case (phase_q)
            PH_FETCH: begin
                nx_d.req       = 1'b1;
                nx_d.dp.ir_en  = 1'b1;
                nx_d.dp.pc_en  = 1'b1;
                nx_d.phase     = PH_EXEC;
            end
            PH_EXEC: begin
                nx_d.phase = PH_FETCH;
                case (opcode_i)
                    OPC_LDA: begin
                        nx_d.req         = 1'b1;
                        nx_d.dp.addr_sel = ADDR_IR;
                        nx_d.dp.acc_en   = 1'b1;
                        nx_d.dp.a_sel    = ASEL_ZERO;
                        nx_d.dp.alu_fn   = ALU_PASS;
                    end
                    OPC_STO: begin
                        nx_d.req            = 1'b1;
                        nx_d.rd             = 1'b0;
                        nx_d.dp.addr_sel    = ADDR_IR;
                        nx_d.dp.drive_wdata = 1'b1;
                    end
                    OPC_ADD, OPC_SUB: begin
                        nx_d.req         = 1'b1;
                        nx_d.dp.addr_sel = ADDR_IR;
                        nx_d.dp.acc_en   = 1'b1;
                        nx_d.dp.a_sel    = ASEL_ACC;
                        nx_d.dp.alu_fn   = (opcode_i == OPC_ADD) ? ALU_ADD : ALU_SUB;
                    end
                    OPC_JMP: begin
                        nx_d.dp.pc_en  = 1'b1;
                        nx_d.dp.pc_src = PCSRC_IR;
                    end
                    OPC_JGE: begin
                        nx_d.dp.pc_en  = !acc_neg_i;
                        nx_d.dp.pc_src = PCSRC_IR;
                    end
                    OPC_JNE: begin
                        nx_d.dp.pc_en  = !acc_zero_i;
                        nx_d.dp.pc_src = PCSRC_IR;
                    end
                    OPC_STP: begin
                        nx_d.phase = PH_HALT;
                    end
                    default: begin
                        nx_d.phase = PH_FETCH;
                    end
                endcase
            end
            default: begin
                nx_d.phase = PH_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= nx_d.phase;
        end
    end

    assign dp_o      = nx_d.dp;
    assign mem_req_o = nx_d.req;
    assign mem_rd_o  = nx_d.rd;
    assign phase_o   = phase_q;

    // R2
    exec_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    // R9
    halt_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HALT) |=> (phase_q == PH_HALT));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_core_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  dp_ctrl_t      dp_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [DW-AW-1:0] opcode_o,
    output logic          acc_neg_o,
    output logic          acc_zero_o,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o
);

    localparam int OPW = DW - AW;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        logic [DW-1:0] ir;
    } regs_t;

    regs_t         r_d;
    regs_t         r_q;
    logic [DW-1:0] alu_a;
    logic [DW-1:0] alu_y;
    logic [AW-1:0] s_field;

    assign s_field = r_q.ir[AW-1:0];
    assign alu_a   = (dp_i.a_sel == ASEL_ZERO) ? '0 : r_q.acc;

    acc_alu #(.DW(DW)) u_alu (
        .a_i  (alu_a),
        .b_i  (mem_rdata_i),
        .fn_i (dp_i.alu_fn),
        .y_o  (alu_y)
    );

    always_comb begin
        r_d = r_q;
        if (dp_i.ir_en) begin
            r_d.ir = mem_rdata_i;
        end
        if (dp_i.acc_en) begin
            r_d.acc = alu_y;
        end
        if (dp_i.pc_en) begin
            r_d.pc = (dp_i.pc_src == PCSRC_IR) ? s_field : r_q.pc + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = (dp_i.addr_sel == ADDR_IR) ? s_field : r_q.pc;
    assign mem_wdata_o = dp_i.drive_wdata ? r_q.acc : '0;
    assign opcode_o    = r_q.ir[DW-1 -: OPW];
    assign acc_neg_o   = r_q.acc[DW-1];
    assign acc_zero_o  = (r_q.acc == '0);
    assign pc_o        = r_q.pc;
    assign acc_o       = r_q.acc;

    // R2
    fetch_advances_pc_chk: assert property (@(posedge clk) disable iff (rst)
        dp_i.ir_en |=> (r_q.pc == $past(r_q.pc) + AW'(1)));

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);

    localparam int OPW = DW - AW;

    dp_ctrl_t         dp_ctrl;
    phase_e           phase;
    logic [OPW-1:0]   opcode;
    logic             acc_neg;
    logic             acc_zero;
    logic [AW-1:0]    pc_q;
    logic [DW-1:0]    acc_q;

    acc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .opcode_i   (opcode),
        .acc_neg_i  (acc_neg),
        .acc_zero_i (acc_zero),
        .dp_o       (dp_ctrl),
        .mem_req_o  (mem_req),
        .mem_rd_o   (mem_rd),
        .phase_o    (phase)
    );

    acc_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .dp_i        (dp_ctrl),
        .mem_rdata_i (mem_rdata),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .opcode_o    (opcode),
        .acc_neg_o   (acc_neg),
        .acc_zero_o  (acc_zero),
        .pc_o        (pc_q),
        .acc_o       (acc_q)
    );

    assign halted = (phase == PH_HALT);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && acc_q == '0 && !halted && mem_req && mem_rd));

    // R9
    halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_req));

    // R4
    wdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !mem_rd) |-> (mem_wdata == '0));

    // R11
    no_req_nonmem_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && opcode >= OPC_JMP) |-> !mem_req);

    // R10
    acc_kept_nonmem_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && opcode >= OPC_JMP) |=> $stable(acc_q));

    // R7
    jge_negative_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && opcode == OPC_JGE && acc_neg) |=> $stable(pc_q));

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'h2, 16'h0003, 16'h0004, 16'h0007},
        '{4'h2, 16'hFFFF, 16'h0001, 16'h0000},
        '{4'h2, 16'h7FFF, 16'h0001, 16'h8000},
        '{4'h3, 16'h0009, 16'h0002, 16'h0007},
        '{4'h3, 16'h0000, 16'h0001, 16'hFFFF},
        '{4'h3, 16'h8000, 16'h0001, 16'h7FFF},
        '{4'h0, 16'h1234, 16'hBEEF, 16'hBEEF},
        '{4'h2, 16'h8001, 16'h8001, 16'h0002}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [4096];
    int          req_cnt;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && !mem_rd) mem[mem_addr] <= mem_wdata;
        if (rst) req_cnt <= 0;
        else if (mem_req) req_cnt <= req_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    task automatic run(output int cyc);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected halt");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        int snap;

        // Table-driven arithmetic and load runs (R3, R4, R5)
        for (int v = 0; v < 8; v++) begin
            clear_mem();
            mem[0] = ins(4'h0, 12'h100);
            mem[1] = ins(VECS[v].op, 12'h101);
            mem[2] = ins(4'h1, 12'h102);
            mem[3] = ins(4'h7, 12'h000);
            mem[12'h100] = VECS[v].a;
            mem[12'h101] = VECS[v].b;
            mem[12'h102] = 16'hA5A5;
            run(cyc);
            chk($sformatf("R5 R3 R4 vec%0d result", v), {16'h0, mem[12'h102]}, {16'h0, VECS[v].exp});
            chk($sformatf("R2 vec%0d cycles", v), cyc, 8);
            chk($sformatf("R11 vec%0d requests", v), req_cnt, 7);
        end

        // R1: reset state, first fetch at 0, accumulator cleared
        clear_mem();
        mem[0] = ins(4'h1, 12'h200);
        mem[1] = ins(4'h7, 12'h000);
        mem[12'h200] = 16'hFFFF;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 halted low in reset", {31'h0, halted}, 0);
        rst = 1'b0;
        chk("R1 first request", {30'h0, mem_req, mem_rd}, 3);
        chk("R1 first address", {20'h0, mem_addr}, 0);
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk("R1 acc cleared", {16'h0, mem[12'h200]}, 0);
        chk("R9 halt cycles", cyc, 4);

        // R9: halted stays quiet
        snap = req_cnt;
        repeat (20) @(negedge clk);
        chk("R9 no requests after halt", req_cnt, snap);
        chk("R9 halted sticky", {31'h0, halted}, 1);

        // R6 R7 R8: jump program
        clear_mem();
        mem[12'h0] = ins(4'h0, 12'h100);
        mem[12'h1] = ins(4'h5, 12'h004);
        mem[12'h2] = ins(4'h1, 12'h110);
        mem[12'h3] = ins(4'h6, 12'h006);
        mem[12'h4] = ins(4'h1, 12'h111);
        mem[12'h5] = ins(4'h7, 12'h000);
        mem[12'h6] = ins(4'h0, 12'h101);
        mem[12'h7] = ins(4'h6, 12'h004);
        mem[12'h8] = ins(4'h5, 12'h00A);
        mem[12'h9] = ins(4'h1, 12'h111);
        mem[12'hA] = ins(4'h0, 12'h102);
        mem[12'hB] = ins(4'h5, 12'h00E);
        mem[12'hC] = ins(4'h1, 12'h111);
        mem[12'hD] = ins(4'h7, 12'h000);
        mem[12'hE] = ins(4'h1, 12'h112);
        mem[12'hF] = ins(4'h4, 12'h005);
        mem[12'h100] = 16'hFFFF;
        mem[12'h101] = 16'h0000;
        mem[12'h102] = 16'h0005;
        mem[12'h111] = 16'h1234;
        run(cyc);
        chk("R7 negative not taken", {16'h0, mem[12'h110]}, 32'hFFFF);
        chk("R8 R7 R6 skipped stores", {16'h0, mem[12'h111]}, 32'h1234);
        chk("R7 positive taken", {16'h0, mem[12'h112]}, 5);
        chk("R6 jump cycles", cyc, 24);
        chk("R11 jump requests", req_cnt, 17);

        // R10: unused codes are no-operations
        clear_mem();
        mem[0] = ins(4'h0, 12'h100);
        mem[1] = 16'h8123;
        mem[2] = 16'hF050;
        mem[3] = ins(4'h1, 12'h110);
        mem[4] = ins(4'h7, 12'h000);
        mem[12'h100] = 16'h0007;
        mem[12'h123] = 16'h4444;
        mem[12'h050] = 16'h5555;
        run(cyc);
        chk("R10 acc kept", {16'h0, mem[12'h110]}, 7);
        chk("R10 target untouched a", {16'h0, mem[12'h123]}, 32'h4444);
        chk("R10 target untouched b", {16'h0, mem[12'h050]}, 32'h5555);
        chk("R11 noop requests", req_cnt, 7);
        chk("R10 noop cycles", cyc, 10);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule